// File: doc/BRIEF.md
# Two-Port Token Semaphore Bank

This block holds a bank of token semaphores that two independent processor ports, left and right, use to share resources without hardware arbitration on the data path. Each port has a semaphore select, an output enable, a write strobe, an address and a data bus. A port asks for a token by writing a 0 to a semaphore and then reads the semaphore back to learn whether it won. A flag reads 0 to the side that holds the token and 1 to everyone else.

Every semaphore keeps one request latch per side and a single shared ownership state. A request that loses is not thrown away. It waits, and it takes the token on its own as soon as the holder writes a 1. A side that no longer wants a token it is waiting for cancels the request by writing a 1. Reads go through a per-port output register. That register captures the flag at the start of a select-plus-output-enable access and holds it until the access ends, so a write from the other port cannot change the value in the middle of a read. The block runs on one clock and has an active-low asynchronous reset.

Top module: `dual_sem_unit`

## Requirements
- R1: The number of semaphores is NUM_SEM (default 8). The lowest log2(NUM_SEM) address bits select one of them, and all higher address bits have no effect on reads or writes.
- R2: On a write (select and write strobe high), only data bit 0 matters. A value of 0 requests the token and a value of 1 releases it or withdraws a request. All other data bits are ignored.
- R3: When a side writes 0 to a free semaphore, that side reads it as 0 from then on and the other side reads it as 1.
- R4: A 0 written by the side that does not hold the token leaves ownership unchanged. The request is kept pending in that side's request latch.
- R5: When the holder writes 1 and the other side has no pending request, the semaphore becomes free. Both sides read 1 and either side may then claim it.
- R6: When the holder writes 1 while the other side has a pending request, ownership passes to the other side on that same clock edge. That side reads 0 until it writes 1 itself.
- R7: A read drives the flag onto every data output bit: all ones when the reading side does not hold the token, all zeros when it does.
- R8: The read register captures the flag on the first clock edge at which select and output enable are both high and the write strobe is low. It then holds that value until one of select or output enable goes low, even if the other port changes the semaphore in the meantime.
- R9: If both sides write 0 to the same free semaphore on the same clock edge, the left side wins (when TIE_LEFT=1, the default) and the right request is kept pending.
- R10: When a side that does not hold the token writes 1, its pending request is cleared, so it will not take ownership later.
- R11: After reset, all request latches are clear and every semaphore reads 1 on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left semaphore select |
| l_oe | input | 1 | Left output enable |
| l_we | input | 1 | Left write strobe |
| l_addr | input | ADDR_W | Left address; low bits pick the semaphore |
| l_wdata | input | DATA_W | Left write data; bit 0 is the request value |
| l_rdata | output | DATA_W | Left read register |
| r_sel | input | 1 | Right semaphore select |
| r_oe | input | 1 | Right output enable |
| r_we | input | 1 | Right write strobe |
| r_addr | input | ADDR_W | Right address; low bits pick the semaphore |
| r_wdata | input | DATA_W | Right write data; bit 0 is the request value |
| r_rdata | output | DATA_W | Right read register |

## Verification
A write takes effect in the request latches and the ownership state at the clock edge where its strobe is sampled. A read access that begins in the following cycle captures the new state at its first edge, and the value is on the output one edge after the access starts. The bench drives every input on the falling edge and samples the read register on the next falling edge. It leaves an idle cycle after each access so that each new read starts a fresh capture. In the freeze test, the bench holds one port's read open across a write from the other port and samples the output on several later falling edges to show that it does not move.

// File: rtl/dsem_pkg.sv
package dsem_pkg;

   typedef enum logic [1:0] {
      SEM_FREE  = 2'd0,
      SEM_LEFT  = 2'd1,
      SEM_RIGHT = 2'd2
   } sem_owner_e;

endpackage

// File: rtl/sem_cell.sv
module sem_cell
   import dsem_pkg::*;
#(
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_l,
   input  logic wbit_l,
   input  logic wr_r,
   input  logic wbit_r,
   output logic held_l,
   output logic held_r
);

   logic       req_l_q, req_r_q;
   logic       req_l_n, req_r_n;
   sem_owner_e owner_q, owner_n;
   sem_owner_e tie_pick;

   // a written 0 is a request, a written 1 withdraws or releases
   assign req_l_n = wr_l ? ~wbit_l : req_l_q;
   assign req_r_n = wr_r ? ~wbit_r : req_r_q;

   generate
      if (TIE_LEFT) begin : g_tie_left
         assign tie_pick = SEM_LEFT;
      end else begin : g_tie_right
         assign tie_pick = SEM_RIGHT;
      end
   endgenerate

   always_comb begin
      owner_n = owner_q;
      unique case (owner_q)
         SEM_LEFT: begin
            if (!req_l_n) owner_n = req_r_n ? SEM_RIGHT : SEM_FREE;
         end
         SEM_RIGHT: begin
            if (!req_r_n) owner_n = req_l_n ? SEM_LEFT : SEM_FREE;
         end
         default: begin
            if (req_l_n && req_r_n) owner_n = tie_pick;
            else if (req_l_n)       owner_n = SEM_LEFT;
            else if (req_r_n)       owner_n = SEM_RIGHT;
            else                    owner_n = SEM_FREE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_l_q <= 1'b0;
         req_r_q <= 1'b0;
         owner_q <= SEM_FREE;
      end else begin
         req_l_q <= req_l_n;
         req_r_q <= req_r_n;
         owner_q <= owner_n;
      end
   end

   assign held_l = (owner_q == SEM_LEFT);
   assign held_r = (owner_q == SEM_RIGHT);

   // the holder always has its own request latch set (R4)
   p_holder_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == SEM_LEFT) |-> req_l_q);

   // without a release by the holder, ownership does not move (R4)
   p_no_steal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == SEM_LEFT && !(wr_l && wbit_l)) |=> (owner_q == SEM_LEFT));

   p_release_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == SEM_LEFT && wr_l && wbit_l && !req_r_q && !(wr_r && !wbit_r))
      |=> (owner_q == SEM_FREE));

   p_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == SEM_RIGHT && wr_r && wbit_r && req_l_q && !wr_l)
      |=> (owner_q == SEM_LEFT));

   p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == SEM_LEFT && wr_r && wbit_r) |=> !req_r_q);

   generate
      if (TIE_LEFT) begin : g_tie_chk
         p_tie_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (owner_q == SEM_FREE && wr_l && !wbit_l && wr_r && !wbit_r)
            |=> (owner_q == SEM_LEFT && req_r_q));
      end
   endgenerate

endmodule

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 13,
   parameter int DATA_W  = 8,
   localparam int IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
   input  logic               sel,
   input  logic               we,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SEM-1:0] flags,
   output logic [NUM_SEM-1:0] wr_stb,
   output logic               wbit,
   output logic               rd_flag
);

   logic [IDX_W-1:0] idx;

   // only the low address bits reach the decoder (R1)
   assign idx  = addr[IDX_W-1:0];
   // only data bit 0 is forwarded (R2)
   assign wbit = wdata[0];

   generate
      for (genvar i = 0; i < NUM_SEM; i++) begin : g_stb
         assign wr_stb[i] = sel && we && (idx == IDX_W'(i));
      end
   endgenerate

   always_comb begin
      rd_flag = 1'b1;
      for (int k = 0; k < NUM_SEM; k++) begin
         if (idx == IDX_W'(k)) rd_flag = flags[k];
      end
   end

endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              oe,
   input  logic              we,
   input  logic              flag,
   output logic [DATA_W-1:0] rdata
);

   logic              act, act_q;
   logic [DATA_W-1:0] rdata_q;

   assign act = sel && oe && !we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         rdata_q <= '1;
      end else begin
         act_q <= act;
         if (act && !act_q) rdata_q <= {DATA_W{flag}};
      end
   end

   assign rdata = rdata_q;

   // held value while the access stays open (R8)
   p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (act && act_q) |=> $stable(rdata_q));

   // the register is always a replicated flag (R7)
   p_replicated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_q == '0) || (rdata_q == '1));

   // a fresh access loads the flag seen at its first edge (R8)
   p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !act_q) |=> (rdata_q == {DATA_W{$past(flag)}}));

endmodule

// File: rtl/dual_sem_unit.sv
module dual_sem_unit
   import dsem_pkg::*;
#(
   parameter int NUM_SEM  = 8,
   parameter int ADDR_W   = 13,
   parameter int DATA_W   = 8,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              l_oe,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sel,
   input  logic              r_oe,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);

   localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

   generate
      if (NUM_SEM < 2 || NUM_SEM > 256) begin : g_bad_num
         $error("dual_sem_unit: NUM_SEM out of range");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("dual_sem_unit: ADDR_W too narrow for NUM_SEM");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dual_sem_unit: DATA_W must be positive");
      end
   endgenerate

   logic [NUM_SEM-1:0] stb_l, stb_r;
   logic [NUM_SEM-1:0] held_l, held_r;
   logic [NUM_SEM-1:0] free_l, free_r;
   logic               wbit_l, wbit_r;
   logic               flag_l, flag_r;

   sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
      .sel(l_sel), .we(l_we), .addr(l_addr), .wdata(l_wdata),
      .flags(free_l), .wr_stb(stb_l), .wbit(wbit_l), .rd_flag(flag_l));

   sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
      .sel(r_sel), .we(r_we), .addr(r_addr), .wdata(r_wdata),
      .flags(free_r), .wr_stb(stb_r), .wbit(wbit_r), .rd_flag(flag_r));

   generate
      for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
         sem_cell #(.TIE_LEFT(TIE_LEFT)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .wr_l(stb_l[i]), .wbit_l(wbit_l),
            .wr_r(stb_r[i]), .wbit_r(wbit_r),
            .held_l(held_l[i]), .held_r(held_r[i]));
         // flags are active low toward the holder
         assign free_l[i] = ~held_l[i];
         assign free_r[i] = ~held_r[i];
      end
   endgenerate

   sem_rd_port #(.DATA_W(DATA_W)) u_rd_l (
      .clk(clk), .rst_n(rst_n), .sel(l_sel), .oe(l_oe), .we(l_we),
      .flag(flag_l), .rdata(l_rdata));

   sem_rd_port #(.DATA_W(DATA_W)) u_rd_r (
      .clk(clk), .rst_n(rst_n), .sel(r_sel), .oe(r_oe), .we(r_we),
      .flag(flag_r), .rdata(r_rdata));

   // a token never has two holders (R3)
   p_single_holder_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(held_l & held_r) && ((held_l & held_r) == '0));

endmodule

// File: tb/sim_dual_sem_unit.sv
module sim_dual_sem_unit;

   localparam int AW = 13;
   localparam int DW = 8;
   localparam int NV = 28;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          l_sel = 0, l_oe = 0, l_we = 0;
   logic          r_sel = 0, r_oe = 0, r_we = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   dual_sem_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .l_sel(l_sel), .l_oe(l_oe), .l_we(l_we), .l_addr(l_addr),
      .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_sel(r_sel), .r_oe(r_oe), .r_we(r_we), .r_addr(r_addr),
      .r_wdata(r_wdata), .r_rdata(r_rdata));

   // vector: {rd, side(0=L), idx[2:0], bit0, expect[7:0], req[3:0]}
   localparam logic [17:0] VEC [0:NV-1] = '{
      {1'b1,1'b0,3'd0,1'b1,8'hFF,4'd11}, // R11 left idle
      {1'b1,1'b1,3'd0,1'b1,8'hFF,4'd11}, // R11 right idle
      {1'b0,1'b0,3'd0,1'b0,8'h00,4'd3},  // R3 left claims 0
      {1'b1,1'b0,3'd0,1'b1,8'h00,4'd3},
      {1'b1,1'b1,3'd0,1'b1,8'hFF,4'd3},
      {1'b0,1'b1,3'd0,1'b0,8'h00,4'd4},  // R4 right request pends
      {1'b1,1'b1,3'd0,1'b1,8'hFF,4'd4},
      {1'b1,1'b0,3'd0,1'b1,8'h00,4'd4},
      {1'b0,1'b0,3'd0,1'b1,8'h00,4'd6},  // R6 release hands over
      {1'b1,1'b1,3'd0,1'b1,8'h00,4'd6},
      {1'b1,1'b0,3'd0,1'b1,8'hFF,4'd6},
      {1'b0,1'b1,3'd0,1'b1,8'h00,4'd5},  // R5 release to free
      {1'b1,1'b0,3'd0,1'b1,8'hFF,4'd5},
      {1'b1,1'b1,3'd0,1'b1,8'hFF,4'd5},
      {1'b0,1'b1,3'd3,1'b0,8'h00,4'd1},  // R1 independent index 3
      {1'b1,1'b1,3'd3,1'b1,8'h00,4'd1},
      {1'b1,1'b0,3'd3,1'b1,8'hFF,4'd1},
      {1'b1,1'b0,3'd0,1'b1,8'hFF,4'd1},
      {1'b0,1'b0,3'd3,1'b0,8'h00,4'd10}, // R10 left pends
      {1'b0,1'b0,3'd3,1'b1,8'h00,4'd10}, // left withdraws
      {1'b0,1'b1,3'd3,1'b1,8'h00,4'd10}, // right releases
      {1'b1,1'b0,3'd3,1'b1,8'hFF,4'd10},
      {1'b1,1'b1,3'd3,1'b1,8'hFF,4'd10},
      {1'b0,1'b0,3'd4,1'b0,8'h00,4'd7},  // R7 full-width replication
      {1'b1,1'b0,3'd4,1'b1,8'h00,4'd7},
      {1'b1,1'b1,3'd4,1'b1,8'hFF,4'd7},
      {1'b0,1'b0,3'd4,1'b1,8'h00,4'd5},
      {1'b1,1'b1,3'd4,1'b1,8'hFF,4'd5}
   };

   task automatic check(input int rq, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d got %h expected %h at %0t", rq, got, exp, $time);
      end
   endtask

   task automatic wr(input bit side, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      if (!side) begin l_sel = 1; l_we = 1; l_addr = a; l_wdata = d; end
      else       begin r_sel = 1; r_we = 1; r_addr = a; r_wdata = d; end
      @(negedge clk);
      if (!side) begin l_sel = 0; l_we = 0; end
      else       begin r_sel = 0; r_we = 0; end
   endtask

   task automatic rd(input bit side, input logic [AW-1:0] a, output logic [DW-1:0] v);
      @(negedge clk);
      if (!side) begin l_sel = 1; l_oe = 1; l_addr = a; end
      else       begin r_sel = 1; r_oe = 1; r_addr = a; end
      @(negedge clk);
      v = side ? r_rdata : l_rdata;
      if (!side) begin l_sel = 0; l_oe = 0; end
      else       begin r_sel = 0; r_oe = 0; end
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      // R11: register reset value before any access
      check(11, l_rdata, 8'hFF);
      check(11, r_rdata, 8'hFF);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [17:0] e;
         e = VEC[i];
         if (e[17]) begin
            rd(e[16], AW'(e[15:13]), v);
            check(int'(e[3:0]), v, e[11:4]);
         end else begin
            wr(e[16], AW'(e[15:13]), {7'h00, e[12]});
         end
      end

      // R1 / R2: high address bits and high data bits have no effect
      wr(1'b0, 13'h1FF5, 8'hFE);
      rd(1'b0, 13'h0005, v);  check(2, v, 8'h00);
      rd(1'b1, 13'h0AA5, v);  check(1, v, 8'hFF);
      wr(1'b0, 13'h0F05, 8'h81);
      rd(1'b1, 13'h0005, v);  check(2, v, 8'hFF);
      rd(1'b0, 13'h1005, v);  check(2, v, 8'hFF);

      // R9: same-edge claim, left wins, right pends
      @(negedge clk);
      l_sel = 1; l_we = 1; l_addr = 13'd6; l_wdata = 8'h00;
      r_sel = 1; r_we = 1; r_addr = 13'd6; r_wdata = 8'h00;
      @(negedge clk);
      l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
      rd(1'b0, 13'd6, v);  check(9, v, 8'h00);
      rd(1'b1, 13'd6, v);  check(9, v, 8'hFF);
      wr(1'b0, 13'd6, 8'h01);
      rd(1'b1, 13'd6, v);  check(9, v, 8'h00);
      wr(1'b1, 13'd6, 8'h01);

      // R8: right read held open while left hands the token over
      wr(1'b0, 13'd7, 8'h00);
      wr(1'b1, 13'd7, 8'h00);
      @(negedge clk);
      r_sel = 1; r_oe = 1; r_addr = 13'd7;
      @(negedge clk);
      check(8, r_rdata, 8'hFF);
      wr(1'b0, 13'd7, 8'h01);
      check(8, r_rdata, 8'hFF);
      @(negedge clk);
      check(8, r_rdata, 8'hFF);
      r_oe = 0;
      @(negedge clk);
      r_oe = 1;
      @(negedge clk);
      check(8, r_rdata, 8'h00);   // R6 handover visible on fresh access
      r_sel = 0; r_oe = 0;
      wr(1'b1, 13'd7, 8'h01);

      // R11: reset in mid-run frees a held token
      wr(1'b0, 13'd2, 8'h00);
      rd(1'b0, 13'd2, v);  check(11, v, 8'h00);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(1'b0, 13'd2, v);  check(11, v, 8'hFF);
      rd(1'b1, 13'd2, v);  check(11, v, 8'hFF);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule